// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit executes the instruction that configures vector length. It decodes a 32-bit instruction word and updates two length registers. The first is the upper bound on vector length, called MVL here. The second is the active vector length, called VL. The new VL comes from one of four sources: a 7-bit immediate, the value of a general-purpose register operand, the loop count register, or the VL already held. VL is always limited to the MVL that results from the same instruction. Immediate lengths are stored as the raw field plus one, so an immediate never yields a length of zero.

Register index zero does not name a register here. Instead it picks the source. With a zero source index and a non-zero destination index, the count register supplies VL. With both indices zero, the immediate supplies VL. The unit can also write the resulting VL to the destination register. It can raise the equal-to-zero bit of condition field 0, and it latches a vertical-first flag. Every result is registered and appears one clock after the valid strobe. The write enables pulse for exactly that one cycle.

Top module: `vlcfg_unit`

## Requirements
- R1: An instruction is accepted only when `valid_i` is high and the minor-opcode bits `insn_i[5:1]` equal 5'b11011. With LSB-0 numbering, the fields are: destination index `insn_i[25:21]`, source index `insn_i[20:16]`, immediate `insn_i[15:9]`, set-MVL flag `insn_i[8]`, set-VL flag `insn_i[7]`, vertical-first flag `insn_i[6]`, record flag `insn_i[0]`. A word with other minor bits changes no state and makes no write.
- R2: With the set-MVL flag high, MVL becomes the immediate plus one (1 to 128). Otherwise MVL keeps its value.
- R3: With the set-VL flag high and both indices zero, VL becomes min(new MVL, immediate plus one), and no destination write occurs.
- R4: With the set-VL flag high, source index zero and destination index non-zero, VL becomes min(new MVL, count register). The count register is compared over its full 64 bits.
- R5: With the set-VL flag high and a non-zero source index, VL becomes min(new MVL, `ra_val_i`), compared over the full 64 bits.
- R6: With the set-VL flag low, VL keeps its value limited to the new MVL. VL never exceeds MVL.
- R7: An accepted instruction with a non-zero destination index pulses `rt_we_o` for one cycle. During that pulse `rt_idx_o` carries the index and `rt_data_o` carries the new VL, zero-extended. With index zero, no write occurs. This includes the read-only form with all three flags low.
- R8: An accepted instruction with the record flag high pulses `cr_we_o` for one cycle. During that pulse `cr_eq_o` is 1 exactly when the new VL is zero.
- R9: Every accepted instruction that is not a step request stores its vertical-first flag in `vfirst_o`.
- R10: A step request has the vertical-first flag high and both set flags low. It leaves MVL, VL and the vertical-first flag unchanged and makes no write.
- R11: While reset is asserted, MVL, VL, the vertical-first flag and both write enables are 0.
- R12: Results appear one clock after the accepting edge. Without `valid_i`, state holds and no write enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | XLEN | Value of the register named by the source index |
| ctr_i | input | XLEN | Loop count register value |
| mvl_o | output | 8 | Held maximum vector length |
| vl_o | output | 8 | Held vector length |
| vfirst_o | output | 1 | Held vertical-first flag |
| rt_we_o | output | 1 | Destination write enable, one-cycle pulse |
| rt_idx_o | output | 5 | Destination register index |
| rt_data_o | output | XLEN | Destination write data |
| cr_we_o | output | 1 | Condition field 0 write enable, one-cycle pulse |
| cr_eq_o | output | 1 | Equal-to-zero bit for condition field 0 |

## Verification
The bench builds the unit with its default 64-bit operand width, and the immediate stays fixed at 7 bits. At that width the whole immediate space is small enough to sweep in full. Every MVL immediate is paired with every VL immediate, which covers each clamp outcome of R2, R3 and R6. At the same width, count and register operands at 2^32, at 2^63 and at all ones test that large values saturate to MVL and do not wrap through a truncated compare.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int IMM_W  = 7;
  localparam int LEN_W  = IMM_W + 1;
  localparam logic [4:0] MINOR_CODE = 5'b11011;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_GPR  = 2'd2,
    SRC_CTR  = 2'd3
  } vl_src_e;

  typedef struct packed {
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] ra;
    logic [IMM_W-1:0] imm;
    logic             set_mvl;
    logic             set_vl;
    logic             vfirst;
    logic             rec;
    logic             legal;
  } insn_f_t;
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
  import vlcfg_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output insn_f_t           fld_o,
  output vl_src_e           src_o,
  output logic              step_o
);
  insn_f_t f;

  always_comb begin
    f.rt      = insn_i[25:21];
    f.ra      = insn_i[20:16];
    f.imm     = insn_i[15:9];
    f.set_mvl = insn_i[8];
    f.set_vl  = insn_i[7];
    f.vfirst  = insn_i[6];
    f.rec     = insn_i[0];
    f.legal   = (insn_i[5:1] == MINOR_CODE);
    fld_o     = f;
    step_o    = f.vfirst & ~f.set_vl & ~f.set_mvl;
    if (!f.set_vl)                src_o = SRC_KEEP;
    else if (f.ra != '0)          src_o = SRC_GPR;
    else if (f.rt != '0)          src_o = SRC_CTR;
    else                          src_o = SRC_IMM;
  end
endmodule

// File: rtl/vlcfg_clamp.sv
module vlcfg_clamp #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 8
) (
  input  logic [XLEN-1:0]  cand_i,
  input  logic [LEN_W-1:0] limit_i,
  output logic [LEN_W-1:0] result_o
);
  logic [XLEN-1:0] limit_ext;

  always_comb begin
    limit_ext = {{(XLEN-LEN_W){1'b0}}, limit_i};
    result_o  = (cand_i < limit_ext) ? cand_i[LEN_W-1:0] : limit_i;
  end
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   ctr_i,
  output logic [LEN_W-1:0]  mvl_o,
  output logic [LEN_W-1:0]  vl_o,
  output logic              vfirst_o,
  output logic              rt_we_o,
  output logic [IDX_W-1:0]  rt_idx_o,
  output logic [XLEN-1:0]   rt_data_o,
  output logic              cr_we_o,
  output logic              cr_eq_o
);
  localparam int PAD_W = XLEN - LEN_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  insn_f_t    fld;
  vl_src_e    src;
  logic       step;

  vlcfg_decode u_decode (
    .insn_i (insn_i),
    .fld_o  (fld),
    .src_o  (src),
    .step_o (step)
  );

  logic [LEN_W-1:0] mvl_q, vl_q;
  logic             vf_q;
  logic             rt_we_q, cr_we_q, cr_eq_q;
  logic [IDX_W-1:0] rt_idx_q;
  logic [XLEN-1:0]  rt_data_q;

  logic [LEN_W-1:0] imm_len, mvl_nxt, vl_nxt;
  logic [XLEN-1:0]  vl_cand;
  logic             accept, rt_we_nxt, cr_we_nxt;

  // next-state logic
  always_comb begin
    imm_len = {1'b0, fld.imm} + LEN_W'(1);
    mvl_nxt = fld.set_mvl ? imm_len : mvl_q;
    case (src)
      SRC_IMM: vl_cand = {{PAD_W{1'b0}}, imm_len};
      SRC_GPR: vl_cand = ra_val_i;
      SRC_CTR: vl_cand = ctr_i;
      default: vl_cand = {{PAD_W{1'b0}}, vl_q};
    endcase
    accept    = valid_i & fld.legal & ~step;
    rt_we_nxt = accept & (fld.rt != '0);
    cr_we_nxt = accept & fld.rec;
  end

  vlcfg_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
    .cand_i   (vl_cand),
    .limit_i  (mvl_nxt),
    .result_o (vl_nxt)
  );

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mvl_q     <= '0;
      vl_q      <= '0;
      vf_q      <= 1'b0;
      rt_we_q   <= 1'b0;
      cr_we_q   <= 1'b0;
      cr_eq_q   <= 1'b0;
      rt_idx_q  <= '0;
      rt_data_q <= '0;
    end else begin
      rt_we_q <= rt_we_nxt;
      cr_we_q <= cr_we_nxt;
      if (accept) begin
        mvl_q     <= mvl_nxt;
        vl_q      <= vl_nxt;
        vf_q      <= fld.vfirst;
        rt_idx_q  <= fld.rt;
        rt_data_q <= {{PAD_W{1'b0}}, vl_nxt};
        cr_eq_q   <= (vl_nxt == '0);
      end
    end
  end

  assign mvl_o     = mvl_q;
  assign vl_o      = vl_q;
  assign vfirst_o  = vf_q;
  assign rt_we_o   = rt_we_q;
  assign rt_idx_o  = rt_idx_q;
  assign rt_data_o = rt_data_q;
  assign cr_we_o   = cr_we_q;
  assign cr_eq_o   = cr_eq_q;
endmodule

// File: rtl/vlcfg_unit_chk.sv
module vlcfg_unit_chk
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [INSN_W-1:0] insn_i,
  input logic [LEN_W-1:0]  mvl_o,
  input logic [LEN_W-1:0]  vl_o,
  input logic              vfirst_o,
  input logic              rt_we_o,
  input logic [IDX_W-1:0]  rt_idx_o,
  input logic [XLEN-1:0]   rt_data_o,
  input logic              cr_we_o,
  input logic              cr_eq_o
);
  logic legal, stepreq;
  assign legal   = (insn_i[5:1] == MINOR_CODE);
  assign stepreq = insn_i[6] & ~insn_i[7] & ~insn_i[8];

  AST_BAD_MINOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !legal) |=> ($stable(vl_o) && $stable(mvl_o) && $stable(vfirst_o) && !rt_we_o && !cr_we_o)); // R1

  AST_MVL_FROM_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && legal && insn_i[8]) |=> (mvl_o == ({1'b0, $past(insn_i[15:9])} + LEN_W'(1)))); // R2

  AST_VL_WITHIN_MVL: assert property (@(posedge clk) disable iff (!rst_n)
    vl_o <= mvl_o); // R6

  AST_RT_CARRIES_VL: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we_o |-> (rt_data_o == XLEN'(vl_o) && rt_idx_o != '0)); // R7

  AST_CR_FROM_VL: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we_o |-> (cr_eq_o == (vl_o == '0))); // R8

  AST_STEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && legal && stepreq) |=> ($stable(vl_o) && $stable(mvl_o) && $stable(vfirst_o) && !rt_we_o && !cr_we_o)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(vl_o) && $stable(mvl_o) && $stable(vfirst_o) && !rt_we_o && !cr_we_o)); // R12
endmodule

bind vlcfg_unit vlcfg_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .mvl_o     (mvl_o),
  .vl_o      (vl_o),
  .vfirst_o  (vfirst_o),
  .rt_we_o   (rt_we_o),
  .rt_idx_o  (rt_idx_o),
  .rt_data_o (rt_data_o),
  .cr_we_o   (cr_we_o),
  .cr_eq_o   (cr_eq_o)
);

// File: tb/test_vlcfg_unit.sv
`timescale 1ns/1ps
module test_vlcfg_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] insn_i;
  logic [63:0] ra_val_i, ctr_i;
  logic [7:0]  mvl_o, vl_o;
  logic        vfirst_o, rt_we_o, cr_we_o, cr_eq_o;
  logic [4:0]  rt_idx_o;
  logic [63:0] rt_data_o;

  always #10 clk = ~clk;  // 50 MHz

  vlcfg_unit #(.XLEN(64)) i_vlcfg_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .ra_val_i(ra_val_i), .ctr_i(ctr_i), .mvl_o(mvl_o), .vl_o(vl_o),
    .vfirst_o(vfirst_o), .rt_we_o(rt_we_o), .rt_idx_o(rt_idx_o),
    .rt_data_o(rt_data_o), .cr_we_o(cr_we_o), .cr_eq_o(cr_eq_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] m_mvl = 0, m_vl = 0;
  logic        m_vf = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] ra,
      input logic [6:0] imm, input bit ms, input bit vs, input bit vf,
      input bit rec, input logic [4:0] minor);
    return {6'd0, rt, ra, imm, ms, vs, vf, minor, rec};
  endfunction

  function automatic logic [63:0] mn(input logic [63:0] a, input logic [63:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic run(input logic [31:0] insn, input logic [63:0] ra,
                     input logic [63:0] ctr, input string tag);
    logic [4:0] rt = insn[25:21];
    logic [4:0] rs = insn[20:16];
    logic [63:0] len = 64'(insn[15:9]) + 64'd1;
    bit ms = insn[8], vs = insn[7], vf = insn[6], rec = insn[0];
    bit acc = (insn[5:1] == 5'b11011) && !(vf && !vs && !ms);
    bit e_rtwe = 0, e_crwe = 0;
    logic [63:0] src;
    if (acc) begin
      if (ms) m_mvl = len;
      if (!vs) src = m_vl;
      else if (rs != 0) src = ra;
      else if (rt != 0) src = ctr;
      else src = len;
      m_vl = mn(src, m_mvl);
      m_vf = vf;
      e_rtwe = (rt != 0);
      e_crwe = rec;
    end
    @(negedge clk);
    insn_i = insn; ra_val_i = ra; ctr_i = ctr; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(mvl_o == m_mvl[7:0], tag, "mvl", 64'(mvl_o), m_mvl);
    chk(vl_o == m_vl[7:0], tag, "vl", 64'(vl_o), m_vl);
    chk(vfirst_o == m_vf, "R9", "vfirst", 64'(vfirst_o), 64'(m_vf));
    chk(rt_we_o == e_rtwe, "R7", "rt_we", 64'(rt_we_o), 64'(e_rtwe));
    if (e_rtwe) begin
      chk(rt_data_o == m_vl, "R7", "rt_data", rt_data_o, m_vl);
      chk(rt_idx_o == rt, "R7", "rt_idx", 64'(rt_idx_o), 64'(rt));
    end
    chk(cr_we_o == e_crwe, "R8", "cr_we", 64'(cr_we_o), 64'(e_crwe));
    if (e_crwe) chk(cr_eq_o == (m_vl == 0), "R8", "cr_eq", 64'(cr_eq_o), 64'(m_vl == 0));
    @(negedge clk);
    chk(!rt_we_o && !cr_we_o, "R12", "pulse_len", 64'({rt_we_o, cr_we_o}), 64'd0);
    chk(vl_o == m_vl[7:0] && mvl_o == m_mvl[7:0], "R12", "hold", 64'(vl_o), m_vl);
  endtask

  localparam int NBIG = 10;
  logic [63:0] big [NBIG];

  initial begin
    big[0] = 64'd0;  big[1] = 64'd1;  big[2] = 64'd63; big[3] = 64'd64;
    big[4] = 64'd65; big[5] = 64'd128; big[6] = 64'd129;
    big[7] = 64'h1_0000_0000; big[8] = 64'h8000_0000_0000_0000; big[9] = '1;
    rst_n = 1'b0; valid_i = 1'b0; insn_i = '0; ra_val_i = '0; ctr_i = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(mvl_o == 0 && vl_o == 0, "R11", "len_reset", 64'(vl_o), 64'd0);
    chk(!vfirst_o && !rt_we_o && !cr_we_o, "R11", "flags_reset",
        64'({vfirst_o, rt_we_o, cr_we_o}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: wrong minor code and absent strobe
    run(mk(5'd3, 5'd0, 7'd9, 1, 1, 0, 1, 5'b11010), 0, 5, "R1");
    insn_i = mk(5'd3, 5'd0, 7'd9, 1, 1, 0, 1, 5'b11011);
    repeat (2) @(negedge clk);
    chk(mvl_o == 0 && vl_o == 0 && !rt_we_o, "R12", "no_valid", 64'(mvl_o), 64'd0);

    // R2, R3: full immediate sweep
    for (int m = 0; m < 128; m++) begin
      run(mk(5'd0, 5'd0, 7'(m), 1, 0, 0, 0, 5'b11011), 0, 0, "R2");
      for (int i = 0; i < 128; i++)
        run(mk(5'd0, 5'd0, 7'(i), 0, 1, 0, 0, 5'b11011), 0, 0, "R3");
    end

    // R6: lowering MVL clamps held VL
    for (int m = 0; m < 128; m += 5) begin
      run(mk(5'd0, 5'd0, 7'd127, 1, 1, 0, 0, 5'b11011), 0, 0, "R6");
      run(mk(5'd0, 5'd0, 7'(m), 1, 0, 0, 0, 5'b11011), 0, 0, "R6");
    end

    // R4, R5, R8: count and register operands with full-width values
    for (int k = 0; k < NBIG; k++) begin
      run(mk(5'd4, 5'd0, 7'd63, 1, 1, 0, 1, 5'b11011), 0, big[k], "R4");
      run(mk(5'd0, 5'd9, 7'd63, 0, 1, 0, 1, 5'b11011), big[k], 7, "R5");
      run(mk(5'd17, 5'd9, 7'd99, 1, 1, 0, 0, 5'b11011), big[k], 0, "R5");
    end

    // R7: read-only form, with and without destination
    run(mk(5'd5, 5'd0, 7'd0, 0, 0, 0, 1, 5'b11011), 0, 0, "R7");
    run(mk(5'd0, 5'd0, 7'd0, 0, 0, 0, 1, 5'b11011), 0, 0, "R7");

    // R9, R10: vertical-first latch and step request
    run(mk(5'd0, 5'd0, 7'd20, 1, 1, 1, 0, 5'b11011), 0, 0, "R9");
    run(mk(5'd6, 5'd0, 7'd3, 0, 0, 1, 1, 5'b11011), 0, 0, "R10");
    run(mk(5'd0, 5'd0, 7'd3, 0, 0, 0, 0, 5'b11011), 0, 0, "R9");
    run(mk(5'd6, 5'd2, 7'd3, 0, 0, 1, 0, 5'b11011), 3, 0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule